// File: doc/BRIEF.md
# Word-Interleaved Multi-Bank Crossbar

This block links a set of requesters (processor load/store ports) to a set of shared memory banks. Consecutive 32-bit words sit in consecutive banks, so requesters that walk through memory in step mostly hit different banks. Together the banks then act like one memory with several ports. Every requester can reach every bank. A request is steered by its address, and each bank picks one winner per cycle with a rotating priority. Read data comes back to the winner one clock after the grant.

Each requester drives a valid/ready request channel. A request is accepted in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is combinational from the current requests and the arbitration state. It is never high without `req_valid`. A requester that sees `req_ready` low must keep `req_valid` high and its payload unchanged until it is accepted. The response channel has no back-pressure. `rsp_valid` is a single-cycle pulse that the requester must take when it appears. The banks are plain behavioural storage arrays with no reset contents.

Top module: `ilv_xbar`

## Requirements
- R1: The word address is the byte address with its low two bits dropped. Word k goes to bank k mod NUM_BANK, which is address bits [3:2] at the defaults. The row inside the bank is taken from the bits above those. The two byte-offset bits never change which word is reached.
- R2: `req_ready[i]` is high only in a cycle where `req_valid[i]` is high. A request is accepted exactly when both are high at a rising clock edge.
- R3: At most one requester is granted per bank per cycle. Requesters that address different banks in the same cycle are all granted in that cycle.
- R4: Each bank keeps a rotating priority that starts at requester 0 after reset. After the bank grants requester w, the search order for the next grant starts at requester (w+1) mod NUM_REQ and wraps around. A requester granted in one cycle loses in the next cycle to any other requester of that bank.
- R5: An accepted read (`req_we`=0) raises `rsp_valid` for that requester in the following cycle only. That response carries the word stored at the addressed location.
- R6: An accepted write (`req_we`=1) updates only the bytes whose `req_be` bit is set, where bit j covers data bits [8j+7:8j]. It produces no `rsp_valid`.
- R7: A requester that is not granted keeps `req_valid` high and `req_addr` stable in the next cycle.
- R8: Once reset is released and before any request is made, `req_ready` and `rsp_valid` are low.
- R9: A request held under R7 is granted within NUM_REQ cycles of first being presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Request present, one bit per requester |
| req_ready | output | NUM_REQ | Request granted this cycle |
| req_we | input | NUM_REQ | 1 = write, 0 = read |
| req_addr | input | NUM_REQ x ADDR_W | Byte address per requester |
| req_be | input | NUM_REQ x DATA_W/8 | Byte enables for writes |
| req_wdata | input | NUM_REQ x DATA_W | Write data |
| rsp_valid | output | NUM_REQ | Read data valid, one cycle after the grant |
| rsp_rdata | output | NUM_REQ x DATA_W | Read data |

## Verification
Each bank has a single rotating pointer. If that pointer goes wrong, the fault shows in the very cycle of the next conflict on that bank: `req_ready` goes to the wrong requester, and the bench compares every ready bit on every clock. A response path that remembers the wrong bank or the wrong read flag shows up one cycle after the grant, as a wrong `rsp_rdata` or a missing or extra `rsp_valid`. Wrong decode or byte-lane handling corrupts memory without any immediate sign. It only appears when that word is read back, so the stimulus fills all of memory first and then reads and writes it many times through every requester.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Width of an index that selects one of n items (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // (base + k) modulo n, used for rotating search orders.
  function automatic int unsigned wrap_add(input int unsigned base,
                                           input int unsigned k,
                                           input int unsigned n);
    return (base + k) % n;
  endfunction
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int unsigned N = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N-1:0]                     req,
  output logic [N-1:0]                     gnt,
  output logic [xbar_pkg::idx_w(N)-1:0]    win,
  output logic                             any
);
  localparam int unsigned IW = xbar_pkg::idx_w(N);

  logic [IW-1:0] ptr_q;

  always_comb begin
    gnt = '0;
    win = '0;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any && req[xbar_pkg::wrap_add(ptr_q, k, N)]) begin
        gnt[xbar_pkg::wrap_add(ptr_q, k, N)] = 1'b1;
        win = IW'(xbar_pkg::wrap_add(ptr_q, k, N));
        any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr_q <= '0;
    else if (any) ptr_q <= (win == IW'(N-1)) ? '0 : win + 1'b1;
  end

  // R4: the previous winner yields to any other competitor
  last_winner_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(any) && ((req & ~(N'(1) << $past(win))) != '0)) |-> !gnt[$past(win)]);
endmodule

// File: rtl/xbar_bank_mem.sv
module xbar_bank_mem #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROW_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                we,
  input  logic [ROW_W-1:0]    row,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);
  localparam int unsigned BE_W = DATA_W / 8;
  localparam int unsigned ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] store [ROWS];

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int j = 0; j < BE_W; j++) begin
        if (be[j]) store[row][j*8 +: 8] <= wdata[j*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdata <= '0;
    else if (en && !we) rdata <= store[row];
  end
endmodule

// File: rtl/ilv_xbar.sv
module ilv_xbar #(
  parameter int unsigned NUM_REQ  = 4,
  parameter int unsigned NUM_BANK = 4,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_REQ-1:0]                   req_valid,
  output logic [NUM_REQ-1:0]                   req_ready,
  input  logic [NUM_REQ-1:0]                   req_we,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0]       req_addr,
  input  logic [NUM_REQ-1:0][DATA_W/8-1:0]     req_be,
  input  logic [NUM_REQ-1:0][DATA_W-1:0]       req_wdata,
  output logic [NUM_REQ-1:0]                   rsp_valid,
  output logic [NUM_REQ-1:0][DATA_W-1:0]       rsp_rdata
);
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(BE_W);
  localparam int unsigned BANK_W = xbar_pkg::idx_w(NUM_BANK);
  localparam int unsigned ROW_W  = ADDR_W - OFF_W - BANK_W;
  localparam int unsigned REQ_W  = xbar_pkg::idx_w(NUM_REQ);

  // Address decode: bank from the low word bits, row from the rest (R1)
  logic [NUM_REQ-1:0][BANK_W-1:0] bank_sel;
  logic [NUM_REQ-1:0][ROW_W-1:0]  row_sel;
  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      bank_sel[i] = req_addr[i][OFF_W +: BANK_W];
      row_sel[i]  = req_addr[i][OFF_W+BANK_W +: ROW_W];
    end
  end

  logic [NUM_REQ-1:0] gnt        [NUM_BANK];
  logic [REQ_W-1:0]   win        [NUM_BANK];
  logic               bank_any   [NUM_BANK];
  logic [DATA_W-1:0]  bank_rdata [NUM_BANK];

  // Request side: per-bank arbitration and winner steering
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [NUM_REQ-1:0] hits;
    always_comb begin
      for (int i = 0; i < NUM_REQ; i++)
        hits[i] = req_valid[i] && (bank_sel[i] == BANK_W'(b));
    end

    xbar_rr_arb #(.N(NUM_REQ)) arb_i (
      .clk(clk), .rst_n(rst_n), .req(hits),
      .gnt(gnt[b]), .win(win[b]), .any(bank_any[b])
    );

    xbar_bank_mem #(.DATA_W(DATA_W), .ROW_W(ROW_W)) mem_i (
      .clk(clk), .rst_n(rst_n),
      .en(bank_any[b]),
      .we(req_we[win[b]]),
      .row(row_sel[win[b]]),
      .be(req_be[win[b]]),
      .wdata(req_wdata[win[b]]),
      .rdata(bank_rdata[b])
    );

    // R3: one granted requester per bank per cycle
    logic [NUM_REQ-1:0] served;
    always_comb begin
      for (int i = 0; i < NUM_REQ; i++)
        served[i] = req_ready[i] && (bank_sel[i] == BANK_W'(b));
    end
    bank_single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(served) <= 1);
  end

  always_comb begin
    req_ready = '0;
    for (int b = 0; b < NUM_BANK; b++)
      req_ready = req_ready | gnt[b];
  end

  // Response side: remember the source bank of each accepted read
  logic [NUM_REQ-1:0]             pend_q;
  logic [NUM_REQ-1:0][BANK_W-1:0] pbank_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      pbank_q <= '0;
    end else begin
      pend_q  <= req_ready & req_valid & ~req_we;
      pbank_q <= bank_sel;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      rsp_valid[i] = pend_q[i];
      rsp_rdata[i] = bank_rdata[pbank_q[i]];
    end
  end

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
    logic [REQ_W:0] wait_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              wait_q <= '0;
      else if (req_valid[i] && !req_ready[i]) wait_q <= (wait_q == '1) ? wait_q : wait_q + 1'b1;
      else                                     wait_q <= '0;
    end

    // R2
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[i] |-> req_valid[i]);
    // R5
    read_resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i] && !req_we[i]) |=> rsp_valid[i]);
    // R6
    write_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i] && req_we[i]) |=> !rsp_valid[i]);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && !req_ready[i]) |=> (req_valid[i] && $stable(req_addr[i])));
    // R9
    bounded_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q < (REQ_W+1)'(NUM_REQ));
  end
endmodule

// File: tb/ilv_xbar_tb.sv
module ilv_xbar_tb_top;
  localparam int NR = 4;
  localparam int NB = 4;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int WORDS = 1 << (AW - 2);
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    bit          act;
    bit          we;
    logic [AW-1:0] addr;
    logic [BW-1:0] be;
    logic [DW-1:0] wdata;
  } job_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0]         req_valid = '0;
  logic [NR-1:0]         req_ready;
  logic [NR-1:0]         req_we = '0;
  logic [NR-1:0][AW-1:0] req_addr = '0;
  logic [NR-1:0][BW-1:0] req_be = '0;
  logic [NR-1:0][DW-1:0] req_wdata = '0;
  logic [NR-1:0]         rsp_valid;
  logic [NR-1:0][DW-1:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_xbar #(.NUM_REQ(NR), .NUM_BANK(NB), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  job_t      jq [NR][$];
  job_t      cur [NR];
  bit        cur_v [NR];
  logic [DW-1:0] ref_mem [WORDS];
  int        rr_ptr [NB];
  bit        exp_rv [NR];
  logic [DW-1:0] exp_rd [NR];

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int word_of(input logic [AW-1:0] a);
    return int'(a >> 2);
  endfunction

  // R1: bank is word index modulo bank count
  function automatic int bank_of(input logic [AW-1:0] a);
    return word_of(a) % NB;
  endfunction

  task automatic push(input int r, input bit we, input int word, input int off,
                      input logic [BW-1:0] be, input logic [DW-1:0] d);
    job_t j;
    j.act = 1; j.we = we; j.addr = AW'(word * 4 + off); j.be = be; j.wdata = d;
    jq[r].push_back(j);
  endtask

  task automatic push_gap(input int r);
    job_t j;
    j.act = 0; j.we = 0; j.addr = '0; j.be = '0; j.wdata = '0;
    jq[r].push_back(j);
  endtask

  // One clock of stimulus plus comparison against the reference model
  task automatic step();
    int eg [NR];
    int wb [NB];
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      if (!cur_v[i]) begin
        req_valid[i] = 1'b0;
        if (jq[i].size() > 0) begin
          job_t j;
          j = jq[i].pop_front();
          if (j.act) begin cur[i] = j; cur_v[i] = 1; end
        end
      end
      if (cur_v[i]) begin
        req_valid[i] = 1'b1;
        req_we[i]    = cur[i].we;
        req_addr[i]  = cur[i].addr;
        req_be[i]    = cur[i].be;
        req_wdata[i] = cur[i].wdata;
      end
    end
    #1;
    // R3/R4: rotating winner per bank
    for (int i = 0; i < NR; i++) eg[i] = 0;
    for (int b = 0; b < NB; b++) begin
      wb[b] = -1;
      for (int k = 0; k < NR; k++) begin
        int c;
        c = (rr_ptr[b] + k) % NR;
        if (wb[b] < 0 && cur_v[c] && bank_of(cur[c].addr) == b) wb[b] = c;
      end
      if (wb[b] >= 0) eg[wb[b]] = 1;
    end
    for (int i = 0; i < NR; i++) begin
      check(req_ready[i] == eg[i][0], "R2/R3/R4 ready", DW'(req_ready[i]), DW'(eg[i]));
      check(rsp_valid[i] == exp_rv[i], "R5/R6 rsp_valid", DW'(rsp_valid[i]), DW'(exp_rv[i]));
      if (exp_rv[i])
        check(rsp_rdata[i] === exp_rd[i], "R5/R1 rsp_rdata", rsp_rdata[i], exp_rd[i]);
    end
    for (int i = 0; i < NR; i++) begin
      exp_rv[i] = 0;
      if (eg[i] != 0) begin
        int w;
        w = word_of(cur[i].addr);
        if (cur[i].we) begin
          for (int j = 0; j < BW; j++)
            if (cur[i].be[j]) ref_mem[w][j*8 +: 8] = cur[i].wdata[j*8 +: 8];
        end else begin
          exp_rv[i] = 1;
          exp_rd[i] = ref_mem[w];
        end
        cur_v[i] = 0; // R7: ungranted jobs stay in cur and are re-driven
      end
    end
    for (int b = 0; b < NB; b++)
      if (wb[b] >= 0) rr_ptr[b] = (wb[b] + 1) % NR;
  endtask

  function automatic bit busy();
    for (int i = 0; i < NR; i++)
      if (cur_v[i] || jq[i].size() > 0) return 1;
    return 0;
  endfunction

  task automatic drain();
    while (busy()) step();
    step();
    step();
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin cur_v[i] = 0; exp_rv[i] = 0; exp_rd[i] = '0; end
    for (int b = 0; b < NB; b++) rr_ptr[b] = 0;
    for (int w = 0; w < WORDS; w++) ref_mem[w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle after reset
    check(req_ready == '0, "R8 ready after reset", DW'(req_ready), 0);
    check(rsp_valid == '0, "R8 rsp_valid after reset", DW'(rsp_valid), 0);

    // R4: all requesters on bank 2 from reset, priority starts at 0
    for (int r = 0; r < NR; r++) push(r, 1, 2 + 4*r, 0, '1, 32'hA500_0000 + r);
    drain();

    // R1/R3/R6: fill every word, requester r writes only bank r (no conflicts)
    for (int k = 0; k < WORDS/NR; k++)
      for (int r = 0; r < NR; r++)
        push(r, 1, k*NR + r, 0, '1, 32'h1000_0000 ^ (k*NR + r) * 32'h9E37_79B9);
    drain();

    // R3/R4/R5: everybody reads bank 1 at once, twice in a row
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < NR; r++) push(r, 0, 1 + 4*(r + t*NR), 0, '0, '0);
    drain();

    // R6: partial byte writes then read back; R1: nonzero byte offsets
    push(0, 1, 7, 0, 4'b0101, 32'hDEAD_BEEF);
    push(1, 1, 8, 3, 4'b1000, 32'hCC00_0000);
    push(2, 1, 9, 1, 4'b0000, 32'hFFFF_FFFF);
    push(0, 0, 7, 2, '0, '0);
    push(1, 0, 8, 1, '0, '0);
    push(2, 0, 9, 3, '0, '0);
    push(3, 0, 7, 0, '0, '0);
    drain();

    // Mixed random traffic with gaps
    for (int n = 0; n < 400; n++)
      for (int r = 0; r < NR; r++) begin
        int sel;
        sel = int'($urandom_range(0, 9));
        if (sel < 2) push_gap(r);
        else push(r, sel < 6, int'($urandom_range(0, WORDS-1)), int'($urandom_range(0, 3)),
                  BW'($urandom), $urandom);
      end
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule